// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block is the configuration front end of a PCI host bridge. It has two host-visible register windows. One is a 32-bit index register that software loads with a configuration address. The other is a data window: each access to it starts one configuration cycle on a simple downstream configuration bus. Each window decodes 0x1000 bytes, and only the low offset bits take part in the access.

On every data-window access the block takes the latched index and the low bits of the data-window offset, and rewrites them into the conventional bus/slot/function/register configuration address. Bit 31 of the index selects a passthrough form. Failing that, bit 0 selects a type-1 form. Any other index is read as a one-hot select form, in which the lowest set bit above bit 10 names the slot. The block then issues one read or write request with byte enables and a byte count over a valid/ready handshake. It stalls the host until the downstream bus answers and returns read data that is right-aligned and little-endian.

Top module: `cfgx_bridge`

## Requirements
- R1: After reset the index register reads 0, and h_done and d_valid are low.
- R2: A write to the index window (h_win=0) updates only the bytes selected by size and h_off[1:0]. A read of the index window returns those bytes of the stored value, right-aligned.
- R3: When index bit 31 is set, d_addr equals the index with h_off[1:0] ORed into bits [1:0]. h_off[2] has no effect in this form.
- R4: When index bit 31 is clear and bit 0 is set, d_addr is index[31:3] followed by h_off[2:0].
- R5: When index bits 31 and 0 are both clear, d_addr[15:11] is the position, counted from bit 11, of the lowest set bit among index[31:11]. d_addr[10:8] is index[10:8], d_addr[7:3] is index[7:3], d_addr[2:0] is h_off[2:0], and d_addr[31:16] is zero.
- R6: In the R5 form with index[31:11] all zero, no downstream request is made. A read returns all ones in the accessed bytes, and a write is discarded.
- R7: Size code h_size 0, 1, 2 (3 acts as 2) gives d_len 1, 2, 4 and d_be equal to that many low ones shifted left by h_off[1:0]. Accesses are naturally aligned.
- R8: d_wdata is the low d_len bytes of h_wdata shifted up by 8*h_off[1:0]. The other bytes are zero.
- R9: Read data on h_rdata is d_rsp_data shifted down by 8*h_off[1:0], with the bytes above d_len cleared.
- R10: Each data access that hits makes exactly one request. d_valid and its fields hold steady until d_ready. h_done pulses for one cycle only after d_rsp_valid.
- R11: Offset bits above bit 2 of either window are ignored, so every offset in the 0x1000-byte window aliases to its low three bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_valid | input | 1 | Host access request, held until h_done |
| h_win | input | 1 | 0 = index window, 1 = data window |
| h_we | input | 1 | 1 = write, 0 = read |
| h_off | input | OFF_W | Byte offset within the window |
| h_size | input | 2 | Access size code (0:1, 1:2, 2/3:4 bytes) |
| h_wdata | input | 32 | Right-aligned write data |
| h_done | output | 1 | One-cycle completion pulse |
| h_rdata | output | 32 | Right-aligned read data, valid with h_done |
| d_valid | output | 1 | Downstream request valid |
| d_ready | input | 1 | Downstream request accepted |
| d_we | output | 1 | Downstream write |
| d_addr | output | 32 | Translated configuration address |
| d_len | output | 3 | Byte count 1, 2 or 4 |
| d_be | output | 4 | Byte enables within the dword |
| d_wdata | output | 32 | Lane-aligned write data |
| d_rsp_valid | input | 1 | Downstream read data or write acknowledge |
| d_rsp_data | input | 32 | Downstream read dword |

## Verification
The checker watches every cycle for properties of the request channel. It checks that the handshake holds steady while d_ready is low, that d_be population matches d_len, and that h_done lasts a single cycle. It also checks the translated address against the latched index for each of the three index forms. Lowest-set-bit slot selection, the miss case that issues no request, sub-word merging into the index register, and read-data lane extraction are covered only by the bench scenarios, which predict each value from the requirements and compare it.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
    localparam int CFG_DW     = 32;
    localparam int CFG_NB     = CFG_DW / 8;
    localparam int CFG_LW     = $clog2(CFG_NB);
    localparam int CFG_CW     = $clog2(CFG_NB) + 1;
    localparam int WIN_OFF_W  = 12;
    localparam int SLOT_BASE  = 11;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_DONE = 2'd3
    } cfgx_state_e;

    typedef struct packed {
        cfgx_state_e          st;
        logic                 we;
        logic [CFG_DW-1:0]    addr;
        logic [CFG_CW-1:0]    len;
        logic [CFG_NB-1:0]    be;
        logic [CFG_DW-1:0]    wdata;
        logic [CFG_LW-1:0]    lane;
        logic [CFG_DW-1:0]    keep;
        logic [CFG_DW-1:0]    rdata;
        logic [CFG_DW-1:0]    idx;
    } cfgx_regs_t;
endpackage

// File: rtl/cfgx_addr_xlate.sv
module cfgx_addr_xlate #(
    parameter int AW      = 32,
    parameter int SLOT_LO = 11,
    localparam int SLOT_W = $clog2(AW - SLOT_LO)
) (
    input  logic [AW-1:0] idx,
    input  logic [2:0]    low,
    output logic [AW-1:0] addr,
    output logic          hit
);
    logic [SLOT_W-1:0] slot;
    logic              found;

    // lowest set bit in the select field
    always_comb begin
        slot  = '0;
        found = 1'b0;
        for (int b = SLOT_LO; b < AW; b++) begin
            if (idx[b] && !found) begin
                slot  = SLOT_W'(b - SLOT_LO);
                found = 1'b1;
            end
        end
    end

    always_comb begin
        addr = '0;
        hit  = 1'b1;
        if (idx[AW-1]) begin
            addr = idx | {{(AW-2){1'b0}}, low[1:0]};
        end else if (idx[0]) begin
            addr = {idx[AW-1:3], low};
        end else begin
            addr[SLOT_LO +: SLOT_W] = slot;
            addr[SLOT_LO-1:3]       = idx[SLOT_LO-1:3];
            addr[2:0]               = low;
            hit                     = found;
        end
    end
endmodule

// File: rtl/cfgx_lane.sv
module cfgx_lane #(
    parameter int DW  = 32,
    localparam int NB = DW / 8,
    localparam int LW = $clog2(NB),
    localparam int CW = $clog2(NB) + 1
) (
    input  logic [1:0]    size,
    input  logic [LW-1:0] lane,
    output logic [CW-1:0] nbytes,
    output logic [NB-1:0] be,
    output logic [DW-1:0] keep_bits,
    output logic [DW-1:0] lane_bits
);
    logic [NB-1:0] bmask;

    always_comb begin
        case (size)
            2'd0:    nbytes = CW'(1);
            2'd1:    nbytes = CW'(2);
            default: nbytes = CW'(NB);
        endcase
        for (int i = 0; i < NB; i++) begin
            bmask[i] = (CW'(i) < nbytes);
        end
        be = bmask << lane;
    end

    for (genvar g = 0; g < NB; g++) begin : g_byte
        assign keep_bits[8*g +: 8] = {8{bmask[g]}};
        assign lane_bits[8*g +: 8] = {8{be[g]}};
    end
endmodule

// File: rtl/cfgx_bridge.sv
module cfgx_bridge
    import cfgx_pkg::*;
#(
    parameter int OFF_W   = WIN_OFF_W,
    parameter int SLOT_LO = SLOT_BASE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_valid,
    input  logic              h_win,
    input  logic              h_we,
    input  logic [OFF_W-1:0]  h_off,
    input  logic [1:0]        h_size,
    input  logic [CFG_DW-1:0] h_wdata,
    output logic              h_done,
    output logic [CFG_DW-1:0] h_rdata,
    output logic              d_valid,
    input  logic              d_ready,
    output logic              d_we,
    output logic [CFG_DW-1:0] d_addr,
    output logic [CFG_CW-1:0] d_len,
    output logic [CFG_NB-1:0] d_be,
    output logic [CFG_DW-1:0] d_wdata,
    input  logic              d_rsp_valid,
    input  logic [CFG_DW-1:0] d_rsp_data
);
    cfgx_regs_t r_q, r_d;

    logic              xl_hit;
    logic [CFG_DW-1:0] xl_addr;
    logic [CFG_CW-1:0] ln_nbytes;
    logic [CFG_NB-1:0] ln_be;
    logic [CFG_DW-1:0] ln_keep;
    logic [CFG_DW-1:0] ln_lanebits;
    logic [CFG_DW-1:0] wr_shifted;
    logic [CFG_DW-1:0] index_view;
    logic              unused_off_hi;

    // window offsets alias above bit 2
    assign unused_off_hi = ^h_off[OFF_W-1:3];

    cfgx_addr_xlate #(.AW(CFG_DW), .SLOT_LO(SLOT_LO)) u_xlate (
        .idx  (r_q.idx),
        .low  (h_off[2:0]),
        .addr (xl_addr),
        .hit  (xl_hit)
    );

    cfgx_lane #(.DW(CFG_DW)) u_lane (
        .size      (h_size),
        .lane      (h_off[CFG_LW-1:0]),
        .nbytes    (ln_nbytes),
        .be        (ln_be),
        .keep_bits (ln_keep),
        .lane_bits (ln_lanebits)
    );

    assign wr_shifted = (h_wdata & ln_keep) << {h_off[CFG_LW-1:0], 3'b000};
    assign index_view = r_q.idx;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (h_valid) begin
                    r_d.rdata = '0;
                    if (!h_win) begin
                        if (h_we) begin
                            r_d.idx = (r_q.idx & ~ln_lanebits) | (wr_shifted & ln_lanebits);
                        end else begin
                            r_d.rdata = (r_q.idx >> {h_off[CFG_LW-1:0], 3'b000}) & ln_keep;
                        end
                        r_d.st = ST_DONE;
                    end else if (!xl_hit) begin
                        if (!h_we) begin
                            r_d.rdata = ln_keep;
                        end
                        r_d.st = ST_DONE;
                    end else begin
                        r_d.we    = h_we;
                        r_d.addr  = xl_addr;
                        r_d.len   = ln_nbytes;
                        r_d.be    = ln_be;
                        r_d.wdata = wr_shifted;
                        r_d.lane  = h_off[CFG_LW-1:0];
                        r_d.keep  = ln_keep;
                        r_d.st    = ST_REQ;
                    end
                end
            end
            ST_REQ: begin
                if (d_ready) begin
                    r_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (d_rsp_valid) begin
                    r_d.rdata = r_q.we ? '0
                              : (d_rsp_data >> {r_q.lane, 3'b000}) & r_q.keep;
                    r_d.st    = ST_DONE;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign h_done  = (r_q.st == ST_DONE);
    assign h_rdata = r_q.rdata;
    assign d_valid = (r_q.st == ST_REQ);
    assign d_we    = r_q.we;
    assign d_addr  = r_q.addr;
    assign d_len   = r_q.len;
    assign d_be    = r_q.be;
    assign d_wdata = r_q.wdata;
endmodule

// File: rtl/cfgx_bridge_chk.sv
module cfgx_bridge_chk
    import cfgx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              h_done,
    input logic              d_valid,
    input logic              d_ready,
    input logic              d_we,
    input logic [CFG_DW-1:0] d_addr,
    input logic [CFG_DW-1:0] d_wdata,
    input logic [CFG_NB-1:0] d_be,
    input logic [CFG_CW-1:0] d_len,
    input logic [CFG_DW-1:0] idx_q
);
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && !d_ready) |=> (d_valid && $stable(d_addr) && $stable(d_be)
                                   && $stable(d_wdata) && $stable(d_we)));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        h_done |=> !h_done);

    p_be_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        d_valid |-> ($countones(d_be) == int'(d_len)));

    p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && idx_q[31]) |-> (d_addr[31:2] == idx_q[31:2]));

    p_type1_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && !idx_q[31] && idx_q[0]) |-> (d_addr[31:3] == idx_q[31:3]));

    p_type0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && !idx_q[31] && !idx_q[0]) |->
            (d_addr[31:16] == 16'h0000 && d_addr[10:3] == idx_q[10:3]));
endmodule

bind cfgx_bridge cfgx_bridge_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .h_done  (h_done),
    .d_valid (d_valid),
    .d_ready (d_ready),
    .d_we    (d_we),
    .d_addr  (d_addr),
    .d_wdata (d_wdata),
    .d_be    (d_be),
    .d_len   (d_len),
    .idx_q   (index_view)
);

// File: tb/cfgx_bridge_bench.sv
module cfgx_bridge_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_valid = 1'b0, h_win = 1'b0, h_we = 1'b0;
    logic [11:0] h_off = '0;
    logic [1:0]  h_size = '0;
    logic [31:0] h_wdata = '0;
    logic        h_done;
    logic [31:0] h_rdata;
    logic        d_valid, d_we;
    logic        d_ready = 1'b0;
    logic [31:0] d_addr, d_wdata;
    logic [2:0]  d_len;
    logic [3:0]  d_be;
    logic        d_rsp_valid = 1'b0;
    logic [31:0] d_rsp_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgx_bridge u_cfgx_bridge (
        .clk(clk), .rst_n(rst_n),
        .h_valid(h_valid), .h_win(h_win), .h_we(h_we), .h_off(h_off),
        .h_size(h_size), .h_wdata(h_wdata), .h_done(h_done), .h_rdata(h_rdata),
        .d_valid(d_valid), .d_ready(d_ready), .d_we(d_we), .d_addr(d_addr),
        .d_len(d_len), .d_be(d_be), .d_wdata(d_wdata),
        .d_rsp_valid(d_rsp_valid), .d_rsp_data(d_rsp_data)
    );

    typedef struct {
        bit          we;
        logic [31:0] addr;
        logic [2:0]  len;
        logic [3:0]  be;
        logic [31:0] wdata;
    } exp_t;

    exp_t exp_q[$];
    exp_t cap;
    int n_checks = 0, n_fail = 0;
    int req_count = 0, rsp_count = 0;
    int ready_gap = 0, rsp_gap = 0, wait_cnt = 0, rsp_cnt = 0;
    bit finished = 1'b0;

    function automatic logic [31:0] model(input logic [31:0] a);
        return {a[15:0] ^ 16'hC3A5, a[31:16] ^ 16'h1E0F} ^ 32'h0102_0408;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // downstream responder and scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            d_rsp_valid = 1'b0;
            if (!rst_n) begin
                d_ready = 1'b0;
            end else if (d_ready && !d_valid) begin
                exp_t e;
                d_ready = 1'b0;
                req_count++;
                wait_cnt = 0;
                rsp_cnt = rsp_gap + 1;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected request", cap.addr, 32'h0);
                end else begin
                    e = exp_q.pop_front();
                    chk(cap.addr == e.addr, "R3/R4/R5 address", cap.addr, e.addr);
                    chk(cap.we == e.we, "R10 direction", 32'(cap.we), 32'(e.we));
                    chk(cap.len == e.len, "R7 length", 32'(cap.len), 32'(e.len));
                    chk(cap.be == e.be, "R7 byte enables", 32'(cap.be), 32'(e.be));
                    if (e.we) chk(cap.wdata == e.wdata, "R8 write data", cap.wdata, e.wdata);
                end
            end else if (rsp_cnt > 0) begin
                rsp_cnt--;
                if (rsp_cnt == 0) begin
                    d_rsp_valid = 1'b1;
                    d_rsp_data = model({cap.addr[31:2], 2'b00});
                    rsp_count++;
                end
            end else if (d_valid && !d_ready) begin
                if (wait_cnt >= ready_gap) begin
                    d_ready = 1'b1;
                    cap.we = d_we; cap.addr = d_addr; cap.len = d_len;
                    cap.be = d_be; cap.wdata = d_wdata;
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    // driver: pushes expected downstream items, runs one host access
    task automatic access(input bit win, input bit we, input logic [11:0] off,
                          input logic [1:0] sz, input logic [31:0] wd,
                          input bit exp_req, input logic [31:0] exp_addr,
                          input logic [31:0] exp_rd, input string req);
        int nb;
        logic [31:0] keep, got;
        exp_t it;
        int r0, s0;
        nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        keep = (nb == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8*nb)) - 32'h1);
        if (win && exp_req) begin
            it.we = we; it.addr = exp_addr; it.len = 3'(nb);
            it.be = 4'(((1 << nb) - 1) << off[1:0]);
            it.wdata = (wd & keep) << (8*off[1:0]);
            exp_q.push_back(it);
            if (!we) exp_rd = (model({exp_addr[31:2], 2'b00}) >> (8*off[1:0])) & keep;
        end else if (win && !we) begin
            exp_rd = keep;
        end
        r0 = req_count; s0 = rsp_count;
        @(negedge clk);
        h_valid = 1'b1; h_win = win; h_we = we; h_off = off; h_size = sz; h_wdata = wd;
        do @(negedge clk); while (!h_done);
        got = h_rdata;
        h_valid = 1'b0;
        if (!we) chk(got == exp_rd, {req, " read data"}, got, exp_rd);
        if (win) begin
            chk(req_count - r0 == (exp_req ? 1 : 0), {req, " request count"},
                32'(req_count - r0), 32'(exp_req ? 1 : 0));
            if (exp_req)
                chk(rsp_count - s0 == 1, "R10 done after response",
                    32'(rsp_count - s0), 32'd1);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(h_done == 1'b0, "R1 h_done in reset", 32'(h_done), 32'd0);
        chk(d_valid == 1'b0, "R1 d_valid in reset", 32'(d_valid), 32'd0);
        rst_n = 1'b1;
        access(0, 0, 12'h000, 2'd2, 0, 0, 0, 32'h0, "R1 index after reset");

        // R2 index window merges and reads by lanes
        access(0, 1, 12'h000, 2'd2, 32'h8000_1234, 0, 0, 0, "R2");
        access(0, 0, 12'h000, 2'd2, 0, 0, 0, 32'h8000_1234, "R2");
        access(0, 1, 12'h001, 2'd0, 32'h0000_77AB, 0, 0, 0, "R2");
        access(0, 0, 12'h002, 2'd1, 0, 0, 0, 32'h0000_8000, "R2");
        access(0, 0, 12'h001, 2'd0, 0, 0, 0, 32'h0000_00AB, "R2");
        access(0, 0, 12'hFFC, 2'd2, 0, 0, 0, 32'h8000_AB34, "R11 index alias");

        // R3 passthrough: offset bit 2 is not added
        access(1, 0, 12'h007, 2'd0, 0, 1, 32'h8000_AB37, 0, "R3 R9");
        access(1, 1, 12'h002, 2'd1, 32'h1234_BEEF, 1, 32'h8000_AB36, 0, "R3 R8");

        // R4 type-1 with slow downstream
        ready_gap = 3; rsp_gap = 5;
        access(0, 1, 12'h000, 2'd2, 32'h0012_3405, 0, 0, 0, "R4 setup");
        access(1, 0, 12'hFFE, 2'd1, 0, 1, 32'h0012_3406, 0, "R4 R11 R10");
        access(1, 1, 12'h004, 2'd2, 32'hCAFE_F00D, 1, 32'h0012_3404, 0, "R4 R10");
        ready_gap = 0; rsp_gap = 1;

        // R5 one-hot select form
        access(0, 1, 12'h000, 2'd2, 32'h0000_8348, 0, 0, 0, "R5 setup");
        access(1, 0, 12'h000, 2'd2, 0, 1, 32'h0000_2348, 0, "R5 slot4");
        access(0, 1, 12'h000, 2'd2, 32'h4000_0010, 0, 0, 0, "R5 setup");
        access(1, 0, 12'h005, 2'd0, 0, 1, 32'h0000_9815, 0, "R5 slot19 R9");
        access(0, 1, 12'h000, 2'd2, 32'h4010_0704, 0, 0, 0, "R5 setup");
        access(1, 1, 12'h001, 2'd0, 32'hDEAD_BEA5, 1, 32'h0000_4F01, 0, "R5 lowest R8");
        access(0, 1, 12'h000, 2'd2, 32'h7FFF_F818, 0, 0, 0, "R5 setup");
        access(1, 0, 12'h002, 2'd1, 0, 1, 32'h0000_001A, 0, "R5 slot0 R7");

        // R6 no select bit set
        access(0, 1, 12'h000, 2'd2, 32'h0000_0344, 0, 0, 0, "R6 setup");
        access(1, 0, 12'h002, 2'd1, 0, 0, 0, 0, "R6 half");
        access(1, 0, 12'h003, 2'd0, 0, 0, 0, 0, "R6 byte");
        access(1, 1, 12'h000, 2'd2, 32'h5555_AAAA, 0, 0, 0, "R6 write");
        access(1, 0, 12'h000, 2'd3, 0, 0, 0, 0, "R6 word");
        access(0, 1, 12'h000, 2'd2, 32'h0000_0801, 0, 0, 0, "R6 recover");
        access(1, 0, 12'h000, 2'd2, 0, 1, 32'h0000_0800, 0, "R6 R4 after miss");
        chk(exp_q.size() == 0, "R10 scoreboard drained", 32'(exp_q.size()), 32'd0);

        repeat (4) @(negedge clk);
        report();
    end
endmodule